// File: doc/BRIEF.md
# SAR Conversion Trigger and Power Sequencer

This block is the digital sequencer that sits in front of a successive-approximation converter core. A 3-bit source code picks one of several trigger sources: three timer outputs, an external control pin (plain or inverted), a free-running continuous generator, and a software start/busy bit. The chosen trigger is read either as single-edge, where one rising edge runs the whole sequence, or as dual-edge, where the rising edge starts acquisition and the next falling edge samples and converts.

The sequencer drives power, acquisition (track) and conversion phase signals to the core. The core is modelled as a fixed number of clock cycles. When a conversion ends, the sequencer captures the core result and raises a sticky data-ready flag. It can optionally drop the core into a low-power sleep after each conversion. A power-up wait is inserted only when the core wakes from sleep or from the disabled state. A master enable holds the core fully powered down. While the enable is low, every trigger is ignored and the result and flag keep their values.

Top module: `sar_trig_seq`

## Requirements
- R1: While `adcEnable` is 0, `corePower` is 0 from the next clock edge and no trigger starts a conversion. When `adcEnable` rises, `corePower` goes to 1 at the next edge, and `coreTrack` follows PWRUP_CYC edges later.
- R2: Source codes 000, 001 and 010 select timer bits 0, 1 and 2. A timer that is not selected has no effect.
- R3: Source code 011 produces no trigger, whatever the other inputs do.
- R4: In single-edge mode (`dualEdge`=0), a rising edge seen while the core is acquiring makes `coreConvert` 1 at the next edge. It stays 1 for CONV_CYC cycles.
- R5: A single-edge rising edge seen while the core is asleep gives PWRUP_CYC cycles with power on and no tracking. ACQ_CYC cycles of tracking follow, then CONV_CYC cycles of conversion.
- R6: In dual-edge mode, a rising edge starts acquisition, and powers the core up for PWRUP_CYC cycles first if it was asleep. The following falling edge makes `coreConvert` 1 at the next edge. A falling edge with no rising edge before it is ignored.
- R7: The edge that ends a conversion also sets `dataReady`. If `autoShutdown` is 1, `corePower` drops at that same edge. Otherwise `coreTrack` is 1 after it.
- R8: Code 110 produces a trigger pulse in the cycle after the code is applied, then another every CONT_PERIOD cycles, with no further stimulus.
- R9: Code 100 uses `extPin` and code 101 uses its inverse. The pin passes through a two-flop synchroniser, so a pin edge starts a conversion on the third clock edge after it.
- R10: Trigger edges that arrive during a conversion are ignored.
- R11: A `swWrite` pulse loads `swWrData` into the software start bit. Code 111 triggers on that bit. `swBusy` reads 1 while the bit is set or a conversion runs, and the bit clears at the edge that ends a conversion.
- R12: `dataReady` stays 1 until a `resultRead` or `readyClear` pulse clears it at the next edge. A conversion ending in the same cycle takes priority, and the flag stays 1.
- R13: `result` takes `coreData` only at the edge that ends a conversion. It keeps its value through sleep and through the disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| adcEnable | input | 1 | Master enable; 0 holds the core fully powered down |
| srcSel | input | 3 | Trigger source code |
| dualEdge | input | 1 | 1 = dual-edge trigger mode, 0 = single-edge |
| autoShutdown | input | 1 | 1 = sleep after each conversion |
| timerTrig | input | 3 | Timer outputs 0..2 |
| extPin | input | 1 | Asynchronous external trigger pin |
| swWrite | input | 1 | Write strobe for the software start bit |
| swWrData | input | 1 | Value written to the software start bit |
| resultRead | input | 1 | Pulse: result has been read, clears data-ready |
| readyClear | input | 1 | Pulse: explicit clear of data-ready |
| coreData | input | RES_W | Conversion value from the core |
| corePower | output | 1 | Core powered (including the power-up wait) |
| coreTrack | output | 1 | Core in acquisition |
| coreConvert | output | 1 | Core holding and converting |
| dataReady | output | 1 | Sticky conversion-complete flag |
| swBusy | output | 1 | Software start bit or conversion in progress |
| result | output | RES_W | Last captured conversion value |

## Verification
A timer or software trigger reaches the controller with no register on the way, so `coreConvert` rises at the first edge after the trigger is seen. The end of conversion, `dataReady`, the `result` capture and the drop of `corePower` under auto-shutdown all land CONV_CYC edges after that. The pin path adds two synchroniser edges. Waking from sleep adds PWRUP_CYC edges, plus ACQ_CYC edges in single-edge mode. The bench drives inputs one time unit after a rising edge and advances a whole number of edges before each sample, with the edge counts taken from these latencies. Each check therefore lands on the first cycle where the result is due, or on the last cycle before it.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_WAKE  = 3'd2,
    ST_ACQ   = 3'd3,
    ST_TRACK = 3'd4,
    ST_CONV  = 3'd5
  } seqStateT;

  localparam logic [2:0] SRC_TMR0    = 3'b000;
  localparam logic [2:0] SRC_TMR1    = 3'b001;
  localparam logic [2:0] SRC_TMR2    = 3'b010;
  localparam logic [2:0] SRC_RSVD    = 3'b011;
  localparam logic [2:0] SRC_PIN     = 3'b100;
  localparam logic [2:0] SRC_PIN_INV = 3'b101;
  localparam logic [2:0] SRC_CONT    = 3'b110;
  localparam logic [2:0] SRC_SOFT    = 3'b111;

  // control -> datapath
  typedef struct packed {
    logic convDone;
    logic inConv;
  } ctrlStrbT;

  // datapath -> control
  typedef struct packed {
    logic rise;
    logic fall;
  } trigEvtT;

endpackage

// File: rtl/adc_seq_dp.sv
`timescale 1ns/1ps
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CONT_PERIOD = 16,
  parameter int RES_W       = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adcEnable,
  input  logic [2:0]       srcSel,
  input  logic [2:0]       timerTrig,
  input  logic             extPin,
  input  logic             swWrite,
  input  logic             swWrData,
  input  logic             resultRead,
  input  logic             readyClear,
  input  logic [RES_W-1:0] coreData,
  input  ctrlStrbT         strb,
  output trigEvtT          ev,
  output logic             dataReady,
  output logic             swBusy,
  output logic [RES_W-1:0] result
);

  localparam int CW = (CONT_PERIOD > 1) ? $clog2(CONT_PERIOD) : 1;

  // pin synchroniser
  logic [SYNC_STAGES-1:0] pinSync;
  logic pinLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinSync <= '0;
    else       pinSync <= {pinSync[SYNC_STAGES-2:0], extPin};
  end
  assign pinLvl = pinSync[SYNC_STAGES-1];

  // continuous pulse generator
  logic          contActive;
  logic [CW-1:0] contCnt;
  logic          contPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      contActive <= 1'b0;
      contCnt    <= '0;
    end else if (!(adcEnable && srcSel == SRC_CONT)) begin
      contActive <= 1'b0;
      contCnt    <= '0;
    end else begin
      contActive <= 1'b1;
      if (contActive) begin
        if (contCnt == '0) contCnt <= CW'(CONT_PERIOD - 1);
        else               contCnt <= contCnt - 1'b1;
      end
    end
  end
  assign contPulse = contActive && (contCnt == '0);

  // software start bit
  logic swBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              swBit <= 1'b0;
    else if (strb.convDone) swBit <= 1'b0;
    else if (swWrite)       swBit <= swWrData;
  end
  assign swBusy = swBit || strb.inConv;

  // source mux
  logic trigLvl;

  always_comb begin
    case (srcSel)
      SRC_TMR0:    trigLvl = timerTrig[0];
      SRC_TMR1:    trigLvl = timerTrig[1];
      SRC_TMR2:    trigLvl = timerTrig[2];
      SRC_RSVD:    trigLvl = 1'b0;
      SRC_PIN:     trigLvl = pinLvl;
      SRC_PIN_INV: trigLvl = !pinLvl;
      SRC_CONT:    trigLvl = contPulse;
      SRC_SOFT:    trigLvl = swBit;
      default:     trigLvl = 1'b0;
    endcase
  end

  // edge detection, suppressed in the cycle the source code changes
  logic       trigPrev;
  logic [2:0] selQ;
  logic       selSame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= 1'b0;
      selQ     <= SRC_RSVD;
    end else begin
      trigPrev <= trigLvl;
      selQ     <= srcSel;
    end
  end
  assign selSame = (srcSel == selQ);
  assign ev.rise = selSame && trigLvl && !trigPrev;
  assign ev.fall = selSame && !trigLvl && trigPrev;

  // result and ready flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReady <= 1'b0;
      result    <= '0;
    end else begin
      if (strb.convDone) begin
        dataReady <= 1'b1;
        result    <= coreData;
      end else if (resultRead || readyClear) begin
        dataReady <= 1'b0;
      end
    end
  end

  a_r12_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    dataReady && !resultRead && !readyClear |=> dataReady);

  a_r13_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.convDone |=> $stable(result));

  a_r11_soft_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.convDone |=> !swBit);

  a_r3_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    srcSel == SRC_RSVD |-> !ev.rise && !ev.fall);

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int PWRUP_CYC = 4,
  parameter int ACQ_CYC   = 2,
  parameter int CONV_CYC  = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     adcEnable,
  input  logic     dualEdge,
  input  logic     autoShutdown,
  input  trigEvtT  ev,
  output ctrlStrbT strb,
  output logic     corePower,
  output logic     coreTrack,
  output logic     coreConvert
);

  localparam int MAXA  = (PWRUP_CYC > ACQ_CYC) ? PWRUP_CYC : ACQ_CYC;
  localparam int MAXC  = (MAXA > CONV_CYC) ? MAXA : CONV_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  seqStateT         state;
  logic [CNT_W-1:0] cnt;
  logic             armed;     // dual: rising edge seen
  logic             autoGo;    // single: rising edge seen during wake
  logic             holdPend;  // dual: falling edge seen during wake
  logic             cntZero;
  logic             goNow;
  logic             holdNow;

  assign cntZero = (cnt == '0);
  assign goNow   = autoGo || (ev.rise && !dualEdge);
  assign holdNow = holdPend || (ev.fall && dualEdge && armed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      cnt      <= '0;
      armed    <= 1'b0;
      autoGo   <= 1'b0;
      holdPend <= 1'b0;
    end else if (!adcEnable) begin
      state    <= ST_OFF;
      cnt      <= '0;
      armed    <= 1'b0;
      autoGo   <= 1'b0;
      holdPend <= 1'b0;
    end else begin
      case (state)
        ST_OFF: begin
          state <= ST_WAKE;
          cnt   <= CNT_W'(PWRUP_CYC - 1);
        end
        ST_SLEEP: begin
          if (ev.rise) begin
            state <= ST_WAKE;
            cnt   <= CNT_W'(PWRUP_CYC - 1);
            if (dualEdge) armed  <= 1'b1;
            else          autoGo <= 1'b1;
          end
        end
        ST_WAKE: begin
          if (ev.rise && dualEdge)  armed    <= 1'b1;
          if (ev.rise && !dualEdge) autoGo   <= 1'b1;
          if (holdNow)              holdPend <= 1'b1;
          if (!cntZero) begin
            cnt <= cnt - 1'b1;
          end else if (goNow) begin
            state  <= ST_ACQ;
            cnt    <= CNT_W'(ACQ_CYC - 1);
            autoGo <= 1'b0;
          end else if (holdNow) begin
            state    <= ST_CONV;
            cnt      <= CNT_W'(CONV_CYC - 1);
            armed    <= 1'b0;
            holdPend <= 1'b0;
          end else begin
            state <= ST_TRACK;
          end
        end
        ST_ACQ: begin
          if (!cntZero) cnt <= cnt - 1'b1;
          else begin
            state <= ST_CONV;
            cnt   <= CNT_W'(CONV_CYC - 1);
          end
        end
        ST_TRACK: begin
          if (!dualEdge) begin
            if (ev.rise) begin
              state <= ST_CONV;
              cnt   <= CNT_W'(CONV_CYC - 1);
            end
          end else if (ev.fall && armed) begin
            state <= ST_CONV;
            cnt   <= CNT_W'(CONV_CYC - 1);
            armed <= 1'b0;
          end else if (ev.rise) begin
            armed <= 1'b1;
          end
        end
        ST_CONV: begin
          if (!cntZero) cnt <= cnt - 1'b1;
          else begin
            state    <= autoShutdown ? ST_SLEEP : ST_TRACK;
            armed    <= 1'b0;
            autoGo   <= 1'b0;
            holdPend <= 1'b0;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assign strb.convDone = (state == ST_CONV) && cntZero;
  assign strb.inConv   = (state == ST_CONV);
  assign corePower     = (state != ST_OFF) && (state != ST_SLEEP);
  assign coreTrack     = (state == ST_TRACK) || (state == ST_ACQ);
  assign coreConvert   = (state == ST_CONV);

  // conversion length checker
  logic [CNT_W:0] convLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            convLen <= '0;
    else if (coreConvert) convLen <= convLen + 1'b1;
    else                  convLen <= '0;
  end

  a_r4_conv_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreConvert) && $past(adcEnable) |-> convLen == (CNT_W+1)'(CONV_CYC));

  a_r1_disabled_off: assert property (@(posedge clk) disable iff (!rstN)
    !adcEnable |=> !corePower);

  a_r7_auto_sleep: assert property (@(posedge clk) disable iff (!rstN)
    strb.convDone && autoShutdown && adcEnable |=> !corePower);

  a_r7_stay_tracking: assert property (@(posedge clk) disable iff (!rstN)
    strb.convDone && !autoShutdown && adcEnable |=> coreTrack);

  a_r5_conv_powered: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreConvert) |-> $past(corePower));

  a_r4_rise_starts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreConvert) && !$past(dualEdge) && $past(state == ST_TRACK) |-> $past(ev.rise));

  a_r6_fall_starts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreConvert) && $past(dualEdge) && $past(state == ST_TRACK) |-> $past(ev.fall));

endmodule

// File: rtl/sar_trig_seq.sv
`timescale 1ns/1ps
module sar_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int PWRUP_CYC   = 4,
  parameter int ACQ_CYC     = 2,
  parameter int CONV_CYC    = 6,
  parameter int CONT_PERIOD = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RES_W       = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             adcEnable,
  input  logic [2:0]       srcSel,
  input  logic             dualEdge,
  input  logic             autoShutdown,
  input  logic [2:0]       timerTrig,
  input  logic             extPin,
  input  logic             swWrite,
  input  logic             swWrData,
  input  logic             resultRead,
  input  logic             readyClear,
  input  logic [RES_W-1:0] coreData,
  output logic             corePower,
  output logic             coreTrack,
  output logic             coreConvert,
  output logic             dataReady,
  output logic             swBusy,
  output logic [RES_W-1:0] result
);

  ctrlStrbT strb;
  trigEvtT  ev;

  adc_seq_ctrl #(
    .PWRUP_CYC(PWRUP_CYC),
    .ACQ_CYC  (ACQ_CYC),
    .CONV_CYC (CONV_CYC)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .adcEnable   (adcEnable),
    .dualEdge    (dualEdge),
    .autoShutdown(autoShutdown),
    .ev          (ev),
    .strb        (strb),
    .corePower   (corePower),
    .coreTrack   (coreTrack),
    .coreConvert (coreConvert)
  );

  adc_seq_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .CONT_PERIOD(CONT_PERIOD),
    .RES_W      (RES_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .adcEnable (adcEnable),
    .srcSel    (srcSel),
    .timerTrig (timerTrig),
    .extPin    (extPin),
    .swWrite   (swWrite),
    .swWrData  (swWrData),
    .resultRead(resultRead),
    .readyClear(readyClear),
    .coreData  (coreData),
    .strb      (strb),
    .ev        (ev),
    .dataReady (dataReady),
    .swBusy    (swBusy),
    .result    (result)
  );

endmodule

// File: tb/sar_trig_seq_test.sv
`timescale 1ns/1ps
module sar_trig_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adcEnable = 1'b0;
  logic [2:0]  srcSel = 3'b011;
  logic        dualEdge = 1'b0;
  logic        autoShutdown = 1'b0;
  logic [2:0]  timerTrig = 3'b000;
  logic        extPin = 1'b0;
  logic        swWrite = 1'b0;
  logic        swWrData = 1'b0;
  logic        resultRead = 1'b0;
  logic        readyClear = 1'b0;
  logic [11:0] coreData = 12'h000;
  logic        corePower, coreTrack, coreConvert, dataReady, swBusy;
  logic [11:0] result;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sar_trig_seq uut (
    .clk(clk), .rstN(rstN), .adcEnable(adcEnable), .srcSel(srcSel),
    .dualEdge(dualEdge), .autoShutdown(autoShutdown), .timerTrig(timerTrig),
    .extPin(extPin), .swWrite(swWrite), .swWrData(swWrData),
    .resultRead(resultRead), .readyClear(readyClear), .coreData(coreData),
    .corePower(corePower), .coreTrack(coreTrack), .coreConvert(coreConvert),
    .dataReady(dataReady), .swBusy(swBusy), .result(result)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearReady();
    readyClear = 1'b1;
    tick(1);
    readyClear = 1'b0;
  endtask

  task automatic testReset();
    check("R1", "power after reset", corePower, 0);
    check("R4", "convert after reset", coreConvert, 0);
    check("R12", "ready after reset", dataReady, 0);
    check("R11", "busy after reset", swBusy, 0);
    check("R13", "result after reset", result, 0);
  endtask

  task automatic testEnable();
    adcEnable = 1'b1;
    tick(1);
    check("R1", "power on enable", corePower, 1);
    check("R1", "no track in wake", coreTrack, 0);
    tick(3);
    check("R1", "still waking", coreTrack, 0);
    tick(1);
    check("R1", "tracking after wake", coreTrack, 1);
  endtask

  task automatic testSingleOn();
    srcSel = 3'b000;
    tick(1);
    coreData = 12'h5A3;
    timerTrig[1] = 1'b1;
    tick(3);
    check("R2", "unselected timer ignored", coreConvert, 0);
    timerTrig[0] = 1'b1;
    tick(1);
    check("R4", "convert after rise", coreConvert, 1);
    check("R4", "track off in convert", coreTrack, 0);
    tick(2);
    timerTrig[0] = 1'b0;
    tick(1);
    timerTrig[0] = 1'b1;
    tick(2);
    check("R4", "convert still on", coreConvert, 1);
    check("R12", "not ready yet", dataReady, 0);
    tick(1);
    check("R4", "convert ended", coreConvert, 0);
    check("R7", "ready set", dataReady, 1);
    check("R13", "result captured", result, 12'h5A3);
    check("R7", "back to track", coreTrack, 1);
    tick(3);
    check("R10", "rise during conversion ignored", coreConvert, 0);
  endtask

  task automatic testReady();
    clearReady();
    check("R12", "explicit clear", dataReady, 0);
    timerTrig[0] = 1'b0;
    tick(1);
    timerTrig[0] = 1'b1;
    tick(6);
    resultRead = 1'b1;
    tick(1);
    resultRead = 1'b0;
    check("R12", "set wins over read", dataReady, 1);
    resultRead = 1'b1;
    tick(1);
    resultRead = 1'b0;
    check("R12", "read clears", dataReady, 0);
    timerTrig[0] = 1'b0;
    tick(1);
  endtask

  task automatic testDualOn();
    dualEdge = 1'b1;
    srcSel = 3'b001;
    tick(1);
    timerTrig[1] = 1'b0;
    tick(3);
    check("R6", "fall without rise ignored", coreConvert, 0);
    check("R6", "still tracking", coreTrack, 1);
    timerTrig[1] = 1'b1;
    tick(1);
    check("R6", "rise only tracks", coreConvert, 0);
    tick(4);
    check("R6", "waiting for fall", coreConvert, 0);
    timerTrig[1] = 1'b0;
    tick(1);
    check("R6", "fall converts", coreConvert, 1);
    tick(5);
    check("R6", "convert held", coreConvert, 1);
    tick(1);
    check("R6", "dual done", dataReady, 1);
    check("R6", "dual convert off", coreConvert, 0);
    clearReady();
  endtask

  task automatic testAutoSingle();
    dualEdge = 1'b0;
    autoShutdown = 1'b1;
    srcSel = 3'b000;
    tick(1);
    timerTrig[0] = 1'b1;
    tick(7);
    check("R7", "power drops at ready", corePower, 0);
    check("R7", "ready with sleep", dataReady, 1);
    readyClear = 1'b1;
    timerTrig[0] = 1'b0;
    tick(1);
    readyClear = 1'b0;
    tick(2);
    check("R7", "stays asleep", corePower, 0);
    coreData = 12'h3C1;
    timerTrig[0] = 1'b1;
    tick(1);
    check("R5", "wake power", corePower, 1);
    check("R5", "no track in wake", coreTrack, 0);
    tick(3);
    check("R5", "wake length", coreTrack, 0);
    tick(1);
    check("R5", "acquire start", coreTrack, 1);
    check("R5", "no convert in acquire", coreConvert, 0);
    tick(1);
    check("R5", "acquire cycle 2", coreTrack, 1);
    tick(1);
    check("R5", "convert after acquire", coreConvert, 1);
    tick(5);
    check("R5", "convert held", coreConvert, 1);
    tick(1);
    check("R5", "done from sleep", dataReady, 1);
    check("R7", "sleep again", corePower, 0);
    check("R13", "result from sleep", result, 12'h3C1);
    timerTrig[0] = 1'b0;
    tick(1);
    clearReady();
  endtask

  task automatic testDualSleep();
    dualEdge = 1'b1;
    tick(1);
    coreData = 12'h7E5;
    timerTrig[0] = 1'b1;
    tick(1);
    check("R6", "dual wake power", corePower, 1);
    check("R6", "dual wake no track", coreTrack, 0);
    tick(3);
    check("R6", "dual wake length", coreTrack, 0);
    tick(1);
    check("R6", "dual track after wake", coreTrack, 1);
    tick(3);
    check("R6", "dual holds off", coreConvert, 0);
    timerTrig[0] = 1'b0;
    tick(1);
    check("R6", "dual fall converts", coreConvert, 1);
    tick(5);
    check("R6", "dual convert held", coreConvert, 1);
    tick(1);
    check("R6", "dual end", coreConvert, 0);
    check("R7", "dual sleep", corePower, 0);
    check("R12", "dual ready", dataReady, 1);
  endtask

  task automatic testEnableOff();
    adcEnable = 1'b0;
    tick(1);
    check("R1", "disabled power", corePower, 0);
    check("R1", "ready kept", dataReady, 1);
    check("R13", "result kept", result, 12'h7E5);
    dualEdge = 1'b0;
    timerTrig[0] = 1'b1;
    tick(3);
    check("R1", "trigger ignored when off", coreConvert, 0);
    check("R1", "still off", corePower, 0);
    check("R12", "ready kept off", dataReady, 1);
    timerTrig[0] = 1'b0;
    tick(1);
    clearReady();
    autoShutdown = 1'b0;
    adcEnable = 1'b1;
    tick(1);
    check("R1", "re-enable power", corePower, 1);
    tick(4);
    check("R1", "re-enable track", coreTrack, 1);
  endtask

  task automatic testCont();
    srcSel = 3'b110;
    tick(1);
    check("R8", "no convert at entry", coreConvert, 0);
    tick(1);
    check("R8", "first conversion", coreConvert, 1);
    tick(5);
    check("R8", "first held", coreConvert, 1);
    tick(1);
    check("R8", "first done", dataReady, 1);
    clearReady();
    tick(8);
    check("R8", "idle before period", coreConvert, 0);
    tick(1);
    check("R8", "second conversion", coreConvert, 1);
    srcSel = 3'b011;
    tick(10);
    check("R8", "stopped", coreConvert, 0);
    check("R8", "second done", dataReady, 1);
    clearReady();
    timerTrig = 3'b111;
    tick(3);
    check("R3", "reserved rise", coreConvert, 0);
    timerTrig = 3'b000;
    tick(3);
    check("R3", "reserved fall", coreConvert, 0);
    check("R3", "reserved no ready", dataReady, 0);
  endtask

  task automatic testPin();
    srcSel = 3'b100;
    tick(1);
    extPin = 1'b1;
    tick(2);
    check("R9", "sync delay", coreConvert, 0);
    tick(1);
    check("R9", "pin converts", coreConvert, 1);
    tick(6);
    check("R9", "pin done", dataReady, 1);
    clearReady();
    srcSel = 3'b101;
    tick(1);
    extPin = 1'b0;
    tick(2);
    check("R9", "inverted sync delay", coreConvert, 0);
    tick(1);
    check("R9", "inverted pin converts", coreConvert, 1);
    tick(6);
    check("R9", "inverted done", dataReady, 1);
    clearReady();
  endtask

  task automatic testSoft();
    srcSel = 3'b111;
    tick(1);
    check("R11", "idle not busy", swBusy, 0);
    swWrite = 1'b1;
    swWrData = 1'b1;
    tick(1);
    swWrite = 1'b0;
    check("R11", "busy after write", swBusy, 1);
    check("R11", "not yet converting", coreConvert, 0);
    tick(1);
    check("R11", "soft converts", coreConvert, 1);
    tick(5);
    check("R11", "busy during conversion", swBusy, 1);
    tick(1);
    check("R11", "busy clears at done", swBusy, 0);
    check("R11", "soft done", dataReady, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog R1..: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testEnable();
    testSingleOn();
    testReady();
    testDualOn();
    testAutoSingle();
    testDualSleep();
    testEnableOff();
    testCont();
    testPin();
    testSoft();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule